// File: doc/BRIEF.md
# Platform Sleep-State Decoder and Indicator Driver

This block watches three active-low chipset status lines and works out which platform sleep state the machine is in. The state comes out as a 3-bit code, along with a one-cycle pulse each time it changes. The block also drives the front-panel indicators from that state and from the AC and battery flags: a power LED, an AC LED, a battery-charging LED and a battery-full LED. A separate output keeps an auxiliary low-power rail enabled except when the machine is off and running without AC.

All inputs first pass through a parameterised synchroniser. A millisecond timebase, derived from the clock, paces blinking. A single blink timer serves both the power LED and the AC LED. Each toggle records the current millisecond value as a stamp. The next toggle fires when the required number of milliseconds has passed since that stamp, or when the millisecond counter has wrapped below the stamp. The second condition keeps blinking alive across counter wrap.

Top module: `pwr_state_led`

## Requirements
- R1: The state is decoded in priority order. `slp_mem_n` high gives S0 (code 3). Otherwise `slp_disk_n` high gives S3 (code 2). Otherwise `resume_rst_n` high gives S5 (code 1). Otherwise the state is DS5 (code 0). Codes 4 to 7 never appear.
- R2: `state_chg` is high for exactly one cycle, in the cycle where `state_code` takes a new value. It stays low when inputs change but the decoded state does not.
- R3: In S0, `led_pwr` is steadily 1 and `led_ac` is 0.
- R4: In S3, `led_ac` is 0 and `led_pwr` toggles every BLINK_MS milliseconds (BLINK_MS×CLK_PER_MS clocks).
- R5: In S5 or DS5 with `ac_present` high, `led_ac` is steadily 1 and `led_pwr` is 0.
- R6: In S5 or DS5 with `ac_present` low, `led_pwr` is 0, `led_ac` blinks with the same timer, and `aux_rail_en` is 0.
- R7: In every other case, `aux_rail_en` is 1.
- R8: A toggle also fires as soon as the MS_W-bit millisecond counter wraps to a value below the last toggle stamp. Regular period toggling then resumes from the new stamp.
- R9: If `batt_present` or `ac_present` is low, `led_chg` and `led_full` are both 0. Otherwise, `chg_zero` high lights only `led_full`, and `chg_zero` low lights only `led_chg`.
- R10: During reset, all four LEDs, `state_code` and `state_chg` are 0, and `aux_rail_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_mem_n | input | 1 | Active-low sleep line; high means fully running |
| slp_disk_n | input | 1 | Active-low deeper sleep line |
| resume_rst_n | input | 1 | Active-low resume-well reset |
| ac_present | input | 1 | High when the adapter is connected |
| batt_present | input | 1 | High when a battery is fitted |
| chg_zero | input | 1 | High when charge current is zero |
| led_pwr | output | 1 | Power indicator |
| led_ac | output | 1 | AC indicator |
| led_chg | output | 1 | Battery charging indicator |
| led_full | output | 1 | Battery full indicator |
| aux_rail_en | output | 1 | Low-power rail enable, low when off without AC |
| state_code | output | 3 | Decoded sleep state code |
| state_chg | output | 1 | One-cycle pulse on a state change |

## Verification
The bench holds the machine in S3 from reset and measures every toggle interval. It expects the short interval where the millisecond counter wraps below the stamp, then the full period again. A design without the wrap test would stop blinking forever once the stamp sits near the top of the counter. Priority vectors set a higher line against lower ones and watch `state_code`; a reordered chain reports the wrong sleep state. Changing lower-priority lines while in S0 must produce no `state_chg` pulse, which catches a design that pulses on any input change.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

   typedef enum logic [2:0] {
      PS_DS5 = 3'd0,
      PS_S5  = 3'd1,
      PS_S3  = 3'd2,
      PS_S0  = 3'd3
   } pstate_e;

   function automatic logic ps_is_off(input pstate_e s);
      return (s == PS_S5) || (s == PS_DS5);
   endfunction

endpackage

// File: rtl/psd_sync.sv
module psd_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("psd_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_s
      $error("psd_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q_o = stg[STAGES-1];
   end
endmodule

// File: rtl/psd_state_dec.sv
module psd_state_dec
   import pwr_state_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    mem_n_i,
   input  logic    disk_n_i,
   input  logic    rsm_n_i,
   output pstate_e state_o,
   output logic    chg_o
);
   pstate_e next_s;

   always_comb begin
      if (mem_n_i)       next_s = PS_S0;
      else if (disk_n_i) next_s = PS_S3;
      else if (rsm_n_i)  next_s = PS_S5;
      else               next_s = PS_DS5;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= PS_DS5;
         chg_o   <= 1'b0;
      end else begin
         state_o <= next_s;
         chg_o   <= (next_s != state_o);
      end
   end

   // R1
   mem_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_n_i |=> (state_o == PS_S0));
   // R1
   disk_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_n_i && disk_n_i) |=> (state_o == PS_S3));
   // R2
   chg_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_o |-> (state_o != $past(state_o)));
   // R2
   chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg_o && !$rose(rst_n)) |-> $stable(state_o));
endmodule

// File: rtl/psd_blink_timer.sv
module psd_blink_timer #(
   parameter int CLK_PER_MS = 32,
   parameter int BLINK_MS   = 1000,
   parameter int MS_W       = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blink_en_i,
   output logic blink_o
);
   localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);
   localparam logic [MS_W:0]    PERIOD   = (MS_W+1)'(BLINK_MS);

   if (CLK_PER_MS < 2) begin : g_bad_clk
      $error("psd_blink_timer: CLK_PER_MS must be at least 2");
   end
   if (BLINK_MS < 1 || BLINK_MS >= (2.0 ** MS_W)) begin : g_bad_blink
      $error("psd_blink_timer: BLINK_MS out of range for MS_W");
   end

   logic [PRE_W-1:0] pre_q;
   logic             ms_tick;
   logic [MS_W-1:0]  ms_now;
   logic [MS_W-1:0]  stamp_q;
   logic             wrapped;
   logic             elapsed;

   assign ms_tick = (pre_q == PRE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         ms_now <= '0;
      end else if (ms_tick) begin
         pre_q  <= '0;
         ms_now <= ms_now + 1'b1;
      end else begin
         pre_q  <= pre_q + 1'b1;
      end
   end

   assign wrapped = (ms_now < stamp_q);
   assign elapsed = ({1'b0, ms_now} >= ({1'b0, stamp_q} + PERIOD));
   assign blink_o = blink_en_i && (wrapped || elapsed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stamp_q <= '0;
      else if (blink_o) stamp_q <= ms_now;
   end

   // R8
   ms_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |=> (ms_now == MS_W'($past(ms_now) + 1'b1)));
   // R4
   blink_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blink_o |=> !blink_o);
   // R8
   stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(blink_o) |-> $stable(stamp_q));
endmodule

// File: rtl/psd_led_drv.sv
module psd_led_drv
   import pwr_state_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  pstate_e state_i,
   input  logic    ac_i,
   input  logic    batt_i,
   input  logic    zero_i,
   input  logic    blink_i,
   output logic    blink_en_o,
   output logic    pwr_o,
   output logic    acl_o,
   output logic    chg_o,
   output logic    full_o,
   output logic    rail_o
);
   logic off_s;
   assign off_s      = ps_is_off(state_i);
   assign blink_en_o = (state_i == PS_S3) || (off_s && !ac_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_o  <= 1'b0;
         acl_o  <= 1'b0;
         rail_o <= 1'b1;
      end else begin
         rail_o <= !(off_s && !ac_i);
         unique case (state_i)
            PS_S0: begin
               pwr_o <= 1'b1;
               acl_o <= 1'b0;
            end
            PS_S3: begin
               if (blink_i) pwr_o <= !pwr_o;
               acl_o <= 1'b0;
            end
            default: begin
               pwr_o <= 1'b0;
               if (ac_i)         acl_o <= 1'b1;
               else if (blink_i) acl_o <= !acl_o;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg_o  <= 1'b0;
         full_o <= 1'b0;
      end else if (!batt_i || !ac_i) begin
         chg_o  <= 1'b0;
         full_o <= 1'b0;
      end else begin
         chg_o  <= !zero_i;
         full_o <= zero_i;
      end
   end

   // R3
   s0_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == PS_S0) |=> (pwr_o && !acl_o));
   // R5
   off_ac_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_s && ac_i) |=> (acl_o && !pwr_o));
   // R6
   rail_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_s && !ac_i) |=> !rail_o);
   // R9
   batt_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ac_i |=> (!chg_o && !full_o));
endmodule

// File: rtl/pwr_state_led.sv
module pwr_state_led
   import pwr_state_pkg::*;
#(
   parameter int CLK_PER_MS  = 32,
   parameter int BLINK_MS    = 1000,
   parameter int MS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slp_mem_n,
   input  logic       slp_disk_n,
   input  logic       resume_rst_n,
   input  logic       ac_present,
   input  logic       batt_present,
   input  logic       chg_zero,
   output logic       led_pwr,
   output logic       led_ac,
   output logic       led_chg,
   output logic       led_full,
   output logic       aux_rail_en,
   output logic [2:0] state_code,
   output logic       state_chg
);
   localparam int NIN = 6;

   if (MS_W < 2 || MS_W > 48) begin : g_bad_msw
      $error("pwr_state_led: MS_W must be within 2..48");
   end

   logic [NIN-1:0] raw_in;
   logic [NIN-1:0] syn_in;
   pstate_e        st;
   logic           blink_en;
   logic           blink;

   assign raw_in = {slp_mem_n, slp_disk_n, resume_rst_n,
                    ac_present, batt_present, chg_zero};

   psd_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   psd_state_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_n_i  (syn_in[5]),
      .disk_n_i (syn_in[4]),
      .rsm_n_i  (syn_in[3]),
      .state_o  (st),
      .chg_o    (state_chg)
   );

   psd_blink_timer #(
      .CLK_PER_MS (CLK_PER_MS),
      .BLINK_MS   (BLINK_MS),
      .MS_W       (MS_W)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .blink_en_i (blink_en),
      .blink_o    (blink)
   );

   psd_led_drv u_led (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_i    (st),
      .ac_i       (syn_in[2]),
      .batt_i     (syn_in[1]),
      .zero_i     (syn_in[0]),
      .blink_i    (blink),
      .blink_en_o (blink_en),
      .pwr_o      (led_pwr),
      .acl_o      (led_ac),
      .chg_o      (led_chg),
      .full_o     (led_full),
      .rail_o     (aux_rail_en)
   );

   assign state_code = st;

   // R9
   batt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(led_chg && led_full));
   // R1
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_code <= 3'd3);
endmodule

// File: tb/tb_pwr_state_led.sv
module tb_pwr_state_led;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mem_n = 1'b0, disk_n = 1'b0, rsm_n = 1'b0;
   logic ac = 1'b0, batt = 1'b0, zero = 1'b0;
   logic led_pwr, led_ac, led_chg, led_full, aux_rail_en, state_chg;
   logic [2:0] state_code;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = !clk;

   pwr_state_led #(.CLK_PER_MS(4), .BLINK_MS(10), .MS_W(6), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .slp_mem_n(mem_n), .slp_disk_n(disk_n),
      .resume_rst_n(rsm_n), .ac_present(ac), .batt_present(batt), .chg_zero(zero),
      .led_pwr(led_pwr), .led_ac(led_ac), .led_chg(led_chg), .led_full(led_full),
      .aux_rail_en(aux_rail_en), .state_code(state_code), .state_chg(state_chg)
   );

   // entry: [15:10] {mem_n,disk_n,rsm_n,ac,batt,zero} [9:8] state
   // [7:6] pwr (2 = don't care) [5:4] ac led [3] rail [2] chg [1] full [0] spare
   localparam logic [15:0] VEC [10] = '{
      16'b100110_11_01_00_1_10_0,
      16'b111011_11_01_00_1_00_0,
      16'b010111_10_10_00_1_01_0,
      16'b011000_10_10_00_1_00_0,
      16'b001110_01_00_01_1_10_0,
      16'b001010_01_00_10_0_00_0,
      16'b000101_00_00_01_1_00_0,
      16'b000011_00_00_10_0_00_0,
      16'b101111_11_01_00_1_01_0,
      16'b011101_10_10_00_1_00_0
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] v);
      @(negedge clk);
      {mem_n, disk_n, rsm_n, ac, batt, zero} = v;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int edges [8];
      int ne;
      int pulses;
      int tg;
      logic prev;

      // R10 reset values
      wait_cyc(3);
      chk("R10 led_pwr", led_pwr, 0);
      chk("R10 led_ac", led_ac, 0);
      chk("R10 led_chg", led_chg, 0);
      chk("R10 led_full", led_full, 0);
      chk("R10 aux_rail_en", aux_rail_en, 1);
      chk("R10 state_code", state_code, 0);
      chk("R10 state_chg", state_chg, 0);
      rst_n = 1'b1;

      // table walk: R1 R3 R5 R6 R7 R9
      for (int k = 0; k < 10; k++) begin
         drive(VEC[k][15:10]);
         wait_cyc(12);
         chk("R1 state_code", state_code, VEC[k][9:8]);
         if (VEC[k][7:6] != 2'd2) chk("R3/R5/R6 led_pwr", led_pwr, VEC[k][7:6]);
         if (VEC[k][5:4] != 2'd2) chk("R3/R4/R5 led_ac", led_ac, VEC[k][5:4]);
         chk("R6/R7 aux_rail_en", aux_rail_en, VEC[k][3]);
         chk("R9 led_chg", led_chg, VEC[k][2]);
         chk("R9 led_full", led_full, VEC[k][1]);
      end

      // R4 and R8: S3 from reset, measure toggle spacing across counter wrap
      @(negedge clk);
      rst_n = 1'b0;
      {mem_n, disk_n, rsm_n, ac, batt, zero} = 6'b010100;
      wait_cyc(3);
      rst_n = 1'b1;
      prev = led_pwr;
      ne = 0;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         if (led_pwr != prev && ne < 8) begin
            edges[ne] = c;
            ne++;
         end
         prev = led_pwr;
      end
      chk("R4 toggle count", ne, 8);
      if (ne == 8) begin
         for (int i = 1; i < 6; i++) chk("R4 blink interval", edges[i] - edges[i-1], 40);
         chk("R8 wrap interval", edges[6] - edges[5], 16);
         chk("R8 interval after wrap", edges[7] - edges[6], 40);
      end

      // R2: one pulse on a real change, none on lower-priority changes
      drive(6'b100100);
      pulses = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (state_chg) pulses++;
      end
      chk("R2 pulse on S3->S0", pulses, 1);
      chk("R1 state after change", state_code, 3);
      drive(6'b111100);
      pulses = 0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (state_chg) pulses++;
      end
      drive(6'b100100);
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (state_chg) pulses++;
      end
      chk("R2 no pulse without state change", pulses, 0);
      chk("R1 S0 held", state_code, 3);

      // R3: power LED steady in S0
      tg = 0;
      prev = led_pwr;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (led_pwr != prev) tg++;
         prev = led_pwr;
      end
      chk("R3 led_pwr toggles in S0", tg, 0);
      chk("R3 led_pwr level", led_pwr, 1);

      // R6: AC LED blinks when off without AC
      drive(6'b001000);
      wait_cyc(8);
      tg = 0;
      prev = led_ac;
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         if (led_ac != prev) tg++;
         prev = led_ac;
      end
      chk("R6 ac blink active", (tg >= 6 && tg <= 9) ? 1 : 0, 1);
      chk("R6 led_pwr off", led_pwr, 0);
      chk("R6 rail low", aux_rail_en, 0);

      // R7: AC returns, rail back high
      drive(6'b001100);
      wait_cyc(8);
      chk("R7 rail high", aux_rail_en, 1);
      chk("R5 led_ac steady on", led_ac, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule